// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a multi-cycle datapath built around microcode. A writable control store holds one microinstruction per microstate. Each microinstruction packs a control word for the datapath together with sequencing fields: a two-bit mode, a two-bit condition selector and an explicit target address. On every clock the sequencer decides the next microaddress. The candidates are the address after the current one, the explicit target, a dispatch slot chosen by the instruction opcode, or a target adjusted by a datapath condition. It then loads that microaddress and the matching microinstruction into registers, so the control word seen by the datapath stays steady for the whole cycle.

A memory wait is written in microcode as a conditional microinstruction that selects the memory-ready input. The microstate repeats itself until the memory answers. The store is loaded at reset with a boot image and can be patched at run time through a plain write port. All pins are plain control or status signals. No streaming handshake exists, and the write port is never back-pressured: a write strobe is accepted in the cycle it is given.

Top module: `ucode_sequencer`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `upc_out` is 0 and `ctrl_out` is 0.
- R2: Reset loads every store address a with a boot word: control field equal to a (zero-extended) and mode next-sequential. An unpatched store therefore steps 0,1,2,… and `ctrl_out` equals `upc_out`.
- R3: Mode 0 (next-sequential) moves to `upc_out`+1 modulo 64, so 63 is followed by 0.
- R4: Mode 1 (jump) moves to the target field.
- R5: Mode 2 (dispatch) moves to 32 + `opcode` (base 32 in the upper bits, the 4 opcode bits in the lowest positions).
- R6: Mode 3 with selector 0, 1 or 2 tests `flag_zero`, `flag_carry` or `flag_neg`, in that order. When the flag is high the next address is the target with bit 0 set. When it is low the next address is the target unchanged.
- R7: Mode 3 with selector 3 tests `mem_ready`. When it is high the next address is the target. When it is low the microaddress and `ctrl_out` hold unchanged.
- R8: The word layout is: bits [1:0] mode, [3:2] condition selector, [9:4] target, [25:10] control field. `ctrl_out` is the control field of the word at `upc_out`.
- R9: With `wr_en` high at a clock edge, `wr_data` is stored at `wr_addr`. It is used the next time that address is entered.
- R10: A write whose address equals the microaddress being entered at the same edge takes effect at once. During a memory self-loop, this means a write to the current address shows on `ctrl_out` in the following cycle. The decision at that edge is still made by the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 4 | Instruction opcode used by dispatch |
| flag_zero | input | 1 | Datapath zero condition |
| flag_carry | input | 1 | Datapath carry condition |
| flag_neg | input | 1 | Datapath negative condition |
| mem_ready | input | 1 | Memory access complete |
| wr_en | input | 1 | Control store write strobe |
| wr_addr | input | 6 | Control store write address |
| wr_data | input | 26 | Microinstruction to write |
| upc_out | output | 6 | Current microaddress |
| ctrl_out | output | 16 | Control word for the datapath |

## Verification
The bench drives every opcode through dispatch and every target through a jump. A sequencer that swapped the opcode bits or the base would land in the wrong slot. It wraps the sequential mode from 63 to 0, which a counter wider than the address would break. It tries every flag selector at both polarities, which catches a selector table in the wrong order or a lost bit-0 merge. It holds memory-ready low for several cycles and patches the waiting microstate during the wait. A design without the write bypass would keep showing the stale control word, and one that re-decided with the new word would leave the loop too early. A long pseudo-random run with patch writes mixed in then compares every cycle against a model built from the rules above.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;
  typedef enum logic [1:0] {
    SQ_NEXT     = 2'd0,
    SQ_JUMP     = 2'd1,
    SQ_DISPATCH = 2'd2,
    SQ_COND     = 2'd3
  } seq_mode_e;

  typedef enum logic [1:0] {
    CS_ZERO  = 2'd0,
    CS_CARRY = 2'd1,
    CS_NEG   = 2'd2,
    CS_READY = 2'd3
  } cond_sel_e;

  localparam int MODE_LSB = 0;
  localparam int CSEL_LSB = 2;
  localparam int TGT_LSB  = 4;
endpackage

// File: rtl/ucs_cond_sel.sv
module ucs_cond_sel
  import ucseq_pkg::*;
(
  input  cond_sel_e csel,
  input  logic      flag_zero,
  input  logic      flag_carry,
  input  logic      flag_neg,
  input  logic      mem_ready,
  output logic      cond_hit,
  output logic      wait_sel
);
  always_comb begin
    wait_sel = 1'b0;
    unique case (csel)
      CS_ZERO:  cond_hit = flag_zero;
      CS_CARRY: cond_hit = flag_carry;
      CS_NEG:   cond_hit = flag_neg;
      default: begin
        cond_hit = mem_ready;
        wait_sel = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ucs_next_addr.sv
module ucs_next_addr
  import ucseq_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int OP_W      = 4,
  parameter int DISP_BASE = 32
) (
  input  seq_mode_e         mode,
  input  logic [ADDR_W-1:0] tgt,
  input  logic [ADDR_W-1:0] upc,
  input  logic [OP_W-1:0]   opcode,
  input  logic              cond_hit,
  input  logic              wait_sel,
  output logic [ADDR_W-1:0] nxt
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(DISP_BASE);
  localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);

  logic [ADDR_W-1:0] disp_addr;
  logic [ADDR_W-1:0] cond_addr;

  assign disp_addr = BASE | ADDR_W'(opcode);

  always_comb begin
    if (wait_sel) cond_addr = cond_hit ? tgt : upc;
    else          cond_addr = cond_hit ? (tgt | ONE) : tgt;
  end

  always_comb begin
    unique case (mode)
      SQ_NEXT:     nxt = upc + ONE;
      SQ_JUMP:     nxt = tgt;
      SQ_DISPATCH: nxt = disp_addr;
      default:     nxt = cond_addr;
    endcase
  end
endmodule

// File: rtl/ucs_store.sv
module ucs_store #(
  parameter int ADDR_W = 6,
  parameter int CTRL_W = 16,
  parameter int WORD_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int CTRL_LSB = WORD_W - CTRL_W;

  logic [WORD_W-1:0] mem [DEPTH];

  // Boot image: control field carries the address, mode is next-sequential.
  function automatic logic [WORD_W-1:0] boot_word(input int a);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CTRL_LSB +: CTRL_W] = CTRL_W'(a);
    return w;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= boot_word(i);
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // Same-edge write to the address being fetched is forwarded.
  assign rd_data = (wr_en && (wr_addr == rd_addr)) ? wr_data : mem[rd_addr];

  assert_store_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import ucseq_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int CTRL_W    = 16,
  parameter int OP_W      = 4,
  parameter int DISP_BASE = 32
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [OP_W-1:0]                      opcode,
  input  logic                                 flag_zero,
  input  logic                                 flag_carry,
  input  logic                                 flag_neg,
  input  logic                                 mem_ready,
  input  logic                                 wr_en,
  input  logic [ADDR_W-1:0]                    wr_addr,
  input  logic [TGT_LSB+ADDR_W+CTRL_W-1:0]     wr_data,
  output logic [ADDR_W-1:0]                    upc_out,
  output logic [CTRL_W-1:0]                    ctrl_out
);
  localparam int WORD_W   = TGT_LSB + ADDR_W + CTRL_W;
  localparam int CTRL_LSB = TGT_LSB + ADDR_W;
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(DISP_BASE);

  logic [ADDR_W-1:0] upc_q;
  logic [WORD_W-1:0] uinst_q;
  logic [WORD_W-1:0] fetch_word;
  logic [ADDR_W-1:0] nxt;
  logic              cond_hit;
  logic              wait_sel;

  seq_mode_e         mode;
  cond_sel_e         csel;
  logic [ADDR_W-1:0] tgt;

  assign mode = seq_mode_e'(uinst_q[MODE_LSB +: 2]);
  assign csel = cond_sel_e'(uinst_q[CSEL_LSB +: 2]);
  assign tgt  = uinst_q[TGT_LSB +: ADDR_W];

  ucs_cond_sel u_cond (
    .csel      (csel),
    .flag_zero (flag_zero),
    .flag_carry(flag_carry),
    .flag_neg  (flag_neg),
    .mem_ready (mem_ready),
    .cond_hit  (cond_hit),
    .wait_sel  (wait_sel)
  );

  ucs_next_addr #(
    .ADDR_W   (ADDR_W),
    .OP_W     (OP_W),
    .DISP_BASE(DISP_BASE)
  ) u_next (
    .mode    (mode),
    .tgt     (tgt),
    .upc     (upc_q),
    .opcode  (opcode),
    .cond_hit(cond_hit),
    .wait_sel(wait_sel),
    .nxt     (nxt)
  );

  ucs_store #(
    .ADDR_W(ADDR_W),
    .CTRL_W(CTRL_W),
    .WORD_W(WORD_W)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(nxt),
    .rd_data(fetch_word)
  );

  // Microaddress and microinstruction register together; boot word 0 is all zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upc_q   <= '0;
      uinst_q <= '0;
    end else begin
      upc_q   <= nxt;
      uinst_q <= fetch_word;
    end
  end

  assign upc_out  = upc_q;
  assign ctrl_out = uinst_q[CTRL_LSB +: CTRL_W];

  assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SQ_NEXT) |=> upc_q == $past(upc_q) + ADDR_W'(1));

  assert_jump_tgt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SQ_JUMP) |=> upc_q == $past(tgt));

  assert_dispatch_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SQ_DISPATCH) |=> upc_q == (BASE | ADDR_W'($past(opcode))));

  assert_flag_branch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SQ_COND && csel != CS_READY) |=> upc_q[ADDR_W-1:1] == $past(tgt[ADDR_W-1:1]));

  assert_mem_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SQ_COND && csel == CS_READY && !mem_ready) |=>
      (upc_q == $past(upc_q)));

  assert_patch_in_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SQ_COND && csel == CS_READY && !mem_ready && wr_en && wr_addr == upc_q) |=>
      uinst_q == $past(wr_data));
endmodule

// File: tb/sim_ucode_sequencer.sv
module sim_ucode_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  opcode = '0;
  logic        flag_zero = 1'b0, flag_carry = 1'b0, flag_neg = 1'b0;
  logic        mem_ready = 1'b1;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [25:0] wr_data = '0;
  logic [5:0]  upc_out;
  logic [15:0] ctrl_out;

  int checks = 0;
  int errors = 0;
  logic [25:0] mmem [64];
  logic [25:0] mcur;
  logic [5:0]  mupc;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #5 clk = ~clk;

  ucode_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .flag_zero(flag_zero),
    .flag_carry(flag_carry), .flag_neg(flag_neg), .mem_ready(mem_ready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .upc_out(upc_out), .ctrl_out(ctrl_out)
  );

  // Word layout per R8: {ctrl[15:0], target[5:0], selector[1:0], mode[1:0]}
  function automatic logic [25:0] mk(input logic [15:0] c, input logic [5:0] t,
                                     input logic [1:0] s, input logic [1:0] m);
    return {c, t, s, m};
  endfunction

  function automatic logic [5:0] mnext(input logic [25:0] w, input logic [5:0] pc);
    logic f;
    case (w[1:0])
      2'd0: return pc + 6'd1;
      2'd1: return w[9:4];
      2'd2: return 6'd32 + {2'b00, opcode};
      default: begin
        if (w[3:2] == 2'd3) return mem_ready ? w[9:4] : pc;
        f = (w[3:2] == 2'd0) ? flag_zero : (w[3:2] == 2'd1) ? flag_carry : flag_neg;
        return f ? (w[9:4] | 6'd1) : w[9:4];
      end
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic step(input string tag);
    logic [5:0] n;
    @(posedge clk);
    n = mnext(mcur, mupc);
    if (wr_en) mmem[wr_addr] = wr_data;
    mcur = mmem[n];
    mupc = n;
    #1;
    check(tag, "upc", upc_out, mupc);
    check(tag, "ctrl", ctrl_out, mcur[25:10]);
    wr_en = 1'b0;
  endtask

  // Patch the address about to be entered so the word runs next cycle (R10 bypass).
  task automatic exec(input logic [25:0] w, input string tag);
    wr_en = 1'b1;
    wr_addr = mnext(mcur, mupc);
    wr_data = w;
    step(tag);
  endtask

  function automatic logic [31:0] nxt_lfsr(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mmem[i] = mk(16'(i), 6'd0, 2'd0, 2'd0);
    mcur = mmem[0];
    mupc = 6'd0;
    #23;
    check("R1", "upc in reset", upc_out, 0);
    check("R1", "ctrl in reset", ctrl_out, 0);
    rst_n = 1'b1;
    #1;
    check("R1", "upc after release", upc_out, 0);

    // R2 / R3: boot image walks through all addresses and wraps.
    for (int k = 0; k < 70; k++) begin
      step("R2");
      check("R2", "ctrl equals upc", ctrl_out, upc_out);
    end

    // R5: every opcode dispatches to 32+op.
    for (int op = 0; op < 16; op++) begin
      exec(mk(16'hD000 | 16'(op), 6'd0, 2'd0, 2'd2), "R8");
      opcode = 4'(op);
      step("R5");
      check("R5", "dispatch slot", upc_out, 32 + op);
    end

    // R4: jump to every target.
    for (int t = 0; t < 64; t++) begin
      exec(mk(16'hA000 | 16'(t), 6'(t), 2'd0, 2'd1), "R8");
      step("R4");
      check("R4", "jump target", upc_out, t);
    end

    // R6: each flag selector at both polarities.
    for (int s = 0; s < 3; s++) begin
      for (int v = 0; v < 2; v++) begin
        exec(mk(16'h6000, 6'h14, 2'(s), 2'd3), "R8");
        flag_zero  = (s == 0) ? v[0] : ~v[0];
        flag_carry = (s == 1) ? v[0] : ~v[0];
        flag_neg   = (s == 2) ? v[0] : ~v[0];
        step("R6");
        check("R6", "cond target", upc_out, 6'h14 | v);
      end
    end

    // R7: memory wait self-loop of varied length.
    for (int d = 1; d < 5; d++) begin
      exec(mk(16'h7700 | 16'(d), 6'd7, 2'd3, 2'd3), "R8");
      begin
        int a;
        a = upc_out;
        mem_ready = 1'b0;
        for (int c = 0; c < d; c++) begin
          step("R7");
          check("R7", "held upc", upc_out, a);
          check("R7", "held ctrl", ctrl_out, 16'h7700 | 16'(d));
        end
        mem_ready = 1'b1;
        step("R7");
        check("R7", "leave wait", upc_out, 7);
      end
    end

    // R10: patch the waiting microstate during the wait.
    exec(mk(16'h5151, 6'd9, 2'd3, 2'd3), "R8");
    begin
      int a;
      a = upc_out;
      mem_ready = 1'b0;
      wr_en = 1'b1;
      wr_addr = 6'(a);
      wr_data = mk(16'hBEEF, 6'd20, 2'd0, 2'd1);
      step("R10");
      check("R10", "upc kept", upc_out, a);
      check("R10", "new ctrl", ctrl_out, 16'hBEEF);
      step("R10");
      check("R10", "new word runs", upc_out, 20);
      mem_ready = 1'b1;
    end

    // R3: sequential wrap from 63 to 0.
    exec(mk(16'h0101, 6'd63, 2'd0, 2'd1), "R8");
    exec(mk(16'h0202, 6'd0, 2'd0, 2'd0), "R3");
    check("R3", "at 63", upc_out, 63);
    step("R3");
    check("R3", "wrap", upc_out, 0);

    // R9: pseudo-random run with random inputs and patch writes.
    for (int k = 0; k < 64; k++) begin
      lfsr = nxt_lfsr(lfsr);
      wr_en = 1'b1;
      wr_addr = 6'(k);
      wr_data = {lfsr[25:2], (lfsr[1:0] == 2'd2) ? 2'd0 : lfsr[1:0]};
      opcode = lfsr[31:28];
      step("R9");
    end
    for (int k = 0; k < 3000; k++) begin
      lfsr = nxt_lfsr(lfsr);
      opcode = lfsr[3:0];
      flag_zero = lfsr[4];
      flag_carry = lfsr[5];
      flag_neg = lfsr[6];
      mem_ready = lfsr[7] | lfsr[8];
      lfsr = nxt_lfsr(lfsr);
      wr_en = (lfsr[2:0] == 3'd0);
      wr_addr = lfsr[8:3];
      wr_data = {lfsr[31:10], lfsr[3:0]};
      step("R9");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule